// File: doc/BRIEF.md
# Memory-Mapped Chip-Select Idle Controller

This block manages the chip-select line and a busy indication for the memory-mapped read path of a serial flash controller. When the read port requests an access, chip select goes low. It then stays low after the access so that prefetching can carry on. Chip select returns high in three cases: the line has been idle for a programmable number of interface clock cycles, software aborts, or the controller is disabled. A release caused by the idle timer produces a single-cycle status pulse.

Every release is followed by a programmable minimum time with chip select high. A request that arrives during this time is held back and granted once the time is over. The busy flag rises on the first accepted access. It does not follow individual transfers; only an abort or a disable clears it. Shifting of command, address and data is handled elsewhere.

Top module: `mmcs_idle_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, cs_n_o is 1, busy_o is 0 and tmo_pulse_o is 0.
- R2: If acc_req_i is 1 while chip select is high, the block is enabled and no minimum-high time is pending, then cs_n_o is 0 and busy_o is 1 from the next clock edge.
- R3: With tmo_en_i = 1 and timeout value V, chip select is released at the clock edge that ends the (V+1)-th consecutive cycle with no request after the last accepted access.
- R4: With tmo_en_i = 0, chip select stays low without limit while the block is enabled and not aborted.
- R5: A request while chip select is low restarts the idle count from V.
- R6: busy_o stays 1 after any release by timeout and drops only through abort or disable.
- R7: After every release, cs_n_o stays high for at least cs_min_high_i cycles. A request made during that time is remembered and drives cs_n_o low one edge after the time ends.
- R8: abort_i = 1 or enable_i = 0 makes cs_n_o 1 and busy_o 0 at the next edge, even when a request arrives in the same cycle, and discards any stalled request.
- R9: tmo_pulse_o is 1 for exactly the one cycle in which chip select has just been released by the timeout. It is never 1 after a release by abort or disable.
- R10: With tmo_en_i = 1 and V = 0, chip select is released at the edge that ends the first idle cycle after an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Controller enable; 0 acts like a held abort |
| abort_i | input | 1 | Abort pulse |
| tmo_en_i | input | 1 | Enables the idle timeout |
| tmo_val_i | input | 16 | Idle timeout value V, in clock cycles |
| cs_min_high_i | input | 6 | Minimum chip-select high time, in cycles |
| acc_req_i | input | 1 | Memory-mapped access request, one bit per cycle |
| cs_n_o | output | 1 | Active-low chip select |
| busy_o | output | 1 | Busy flag |
| tmo_pulse_o | output | 1 | One-cycle pulse on a release by timeout |

## Verification
The minimum-high check expects cs_min_high_i to stay constant from a release until chip select is asserted again. The stimulus changes that field only while the block is disabled or long after an assertion. The properties sample all inputs at the rising edge and take them to be synchronous. The bench therefore changes every input only at the falling edge. Timeout values and minimum-high counts are kept small, so that many releases and re-assertions occur within one run.

// File: rtl/mmcs_pkg.sv
package mmcs_pkg;
    typedef struct packed {
        logic cs;
        logic busy;
        logic pend;
        logic pulse;
    } mmcs_state_t;
endpackage

// File: rtl/mmcs_down_cnt.sv
module mmcs_down_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    input  logic         dec_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = val_i;
        else if (dec_i && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/mmcs_idle_ctrl.sv
module mmcs_idle_ctrl #(
    parameter int TMO_W  = 16,
    parameter int HOLD_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              abort_i,
    input  logic              tmo_en_i,
    input  logic [TMO_W-1:0]  tmo_val_i,
    input  logic [HOLD_W-1:0] cs_min_high_i,
    input  logic              acc_req_i,
    output logic              cs_n_o,
    output logic              busy_o,
    output logic              tmo_pulse_o
);
    import mmcs_pkg::*;

    mmcs_state_t st_d, st_q;
    logic kill, want, idle_zero, hold_zero;
    logic idle_load, idle_dec, hold_load, hold_dec, tmo_release;

    assign kill = abort_i | ~enable_i;
    assign want = acc_req_i | st_q.pend;

    mmcs_down_cnt #(.W(TMO_W)) idle_cnt_i (
        .clk(clk), .rst_n(rst_n), .load_i(idle_load), .val_i(tmo_val_i),
        .dec_i(idle_dec), .zero_o(idle_zero)
    );

    mmcs_down_cnt #(.W(HOLD_W)) hold_cnt_i (
        .clk(clk), .rst_n(rst_n), .load_i(hold_load), .val_i(cs_min_high_i),
        .dec_i(hold_dec), .zero_o(hold_zero)
    );

    always_comb begin
        tmo_release = ~kill & st_q.cs & ~acc_req_i & tmo_en_i & idle_zero;
        idle_load   = ~kill & ((st_q.cs & acc_req_i) | (~st_q.cs & hold_zero & want));
        idle_dec    = st_q.cs & ~acc_req_i & tmo_en_i;
        hold_load   = st_q.cs & (kill | tmo_release);
        hold_dec    = ~st_q.cs;

        st_d = st_q;
        if (kill) begin
            st_d.cs    = 1'b0;
            st_d.busy  = 1'b0;
            st_d.pend  = 1'b0;
            st_d.pulse = 1'b0;
        end else begin
            st_d.cs    = st_q.cs ? ~tmo_release : (hold_zero & want);
            st_d.busy  = st_q.busy | st_d.cs;
            st_d.pend  = ~st_q.cs & ~hold_zero & want;
            st_d.pulse = tmo_release;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cs_n_o      = ~st_q.cs;
    assign busy_o      = st_q.busy;
    assign tmo_pulse_o = st_q.pulse;
endmodule

// File: rtl/mmcs_idle_ctrl_chk.sv
module mmcs_idle_ctrl_chk #(
    parameter int HOLD_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable_i,
    input logic              abort_i,
    input logic              tmo_en_i,
    input logic [HOLD_W-1:0] cs_min_high_i,
    input logic              acc_req_i,
    input logic              cs_n_o,
    input logic              busy_o,
    input logic              tmo_pulse_o
);
    logic [6:0] hi_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                hi_run_q <= 7'd127;
        else if (!cs_n_o)          hi_run_q <= 7'd0;
        else if (hi_run_q != 7'd127) hi_run_q <= hi_run_q + 7'd1;
    end

    assert_kill_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_i || !enable_i) |=> (cs_n_o && !busy_o));

    assert_busy_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && enable_i && !abort_i) |=> busy_o);

    assert_hold_forever_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_o && !tmo_en_i && enable_i && !abort_i) |=> !cs_n_o);

    assert_pulse_on_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_pulse_o |-> (cs_n_o && busy_o));

    assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_pulse_o |=> !tmo_pulse_o);

    assert_min_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> (hi_run_q >= {1'b0, cs_min_high_i}));

    assert_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_o && enable_i && !abort_i) |=> busy_o);
endmodule

bind mmcs_idle_ctrl mmcs_idle_ctrl_chk #(.HOLD_W(HOLD_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .abort_i(abort_i),
    .tmo_en_i(tmo_en_i), .cs_min_high_i(cs_min_high_i), .acc_req_i(acc_req_i),
    .cs_n_o(cs_n_o), .busy_o(busy_o), .tmo_pulse_o(tmo_pulse_o)
);

// File: tb/mmcs_idle_ctrl_tb_top.sv
module mmcs_idle_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable_i = 1'b0, abort_i = 1'b0, tmo_en_i = 1'b0, acc_req_i = 1'b0;
    logic [15:0] tmo_val_i = 16'd0;
    logic [5:0]  cs_min_high_i = 6'd0;
    logic        cs_n_o, busy_o, tmo_pulse_o;

    int    n_chk = 0, n_fail = 0, cyc = 0;
    bit    done = 0;
    string tag = "R1";

    // reference model state
    bit m_cs = 0, m_busy = 0, m_pend = 0, m_pulse = 0;
    int m_idle = 0, m_hold = 0;

    always #2 clk = ~clk;

    mmcs_idle_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .abort_i(abort_i),
        .tmo_en_i(tmo_en_i), .tmo_val_i(tmo_val_i), .cs_min_high_i(cs_min_high_i),
        .acc_req_i(acc_req_i), .cs_n_o(cs_n_o), .busy_o(busy_o), .tmo_pulse_o(tmo_pulse_o)
    );

    // Behavioural model: idle_left counts remaining idle cycles, hold_left the
    // remaining forced-high cycles; requests seen during hold are remembered.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cs = 0; m_busy = 0; m_pend = 0; m_pulse = 0; m_idle = 0; m_hold = 0;
        end else begin
            m_pulse = 0;
            if (abort_i || !enable_i) begin
                if (m_cs) m_hold = cs_min_high_i;
                else if (m_hold > 0) m_hold--;
                m_cs = 0; m_busy = 0; m_pend = 0;
            end else if (m_cs) begin
                if (acc_req_i) m_idle = tmo_val_i;
                else if (tmo_en_i) begin
                    if (m_idle == 0) begin
                        m_cs = 0; m_pulse = 1; m_hold = cs_min_high_i;
                    end else m_idle--;
                end
            end else begin
                if (m_hold > 0) begin
                    m_hold--;
                    m_pend = m_pend || acc_req_i;
                end else if (m_pend || acc_req_i) begin
                    m_cs = 1; m_busy = 1; m_pend = 0; m_idle = tmo_val_i;
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not finish (actual cycle %0d, expected < 100000)", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk1(input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk1("cs_n", cs_n_o, ~m_cs);
            chk1("busy", busy_o, m_busy);
            chk1("pulse", tmo_pulse_o, m_pulse);
        end
    endtask

    task automatic req_pulse();
        acc_req_i = 1; tick(); acc_req_i = 0;
    endtask

    initial begin
        tag = "R1";
        tick(3);
        rst_n = 1;
        tick();

        tag = "R2";
        enable_i = 1; tmo_en_i = 0; cs_min_high_i = 2; tmo_val_i = 5;
        req_pulse();
        chk1("cs_n low after request", cs_n_o, 1'b0);

        tag = "R4";
        tick(40);
        chk1("cs_n still low", cs_n_o, 1'b0);

        tag = "R3,R9";
        tmo_en_i = 1; tmo_val_i = 5;
        req_pulse();
        tick(5);
        chk1("cs_n before expiry", cs_n_o, 1'b0);
        tick();
        chk1("cs_n released", cs_n_o, 1'b1);
        chk1("pulse", tmo_pulse_o, 1'b1);
        tick();
        chk1("pulse single", tmo_pulse_o, 1'b0);

        tag = "R6";
        tick(10);
        chk1("busy after timeout", busy_o, 1'b1);

        tag = "R7";
        cs_min_high_i = 3; tmo_val_i = 1;
        req_pulse(); tick(3);
        req_pulse(); tick(8);
        cs_min_high_i = 0;
        req_pulse(); tick(4);
        req_pulse(); tick(6);

        tag = "R5";
        tmo_val_i = 4; cs_min_high_i = 2;
        for (int k = 0; k < 8; k++) begin
            req_pulse(); tick(3);
        end
        chk1("cs_n held by reloads", cs_n_o, 1'b0);
        tick(8);

        tag = "R8";
        tmo_en_i = 0;
        req_pulse(); tick(2);
        abort_i = 1; acc_req_i = 1; tick();
        chk1("abort release", cs_n_o, 1'b1);
        chk1("abort busy", busy_o, 1'b0);
        abort_i = 0; acc_req_i = 0; tick(5);
        req_pulse(); tick(2);
        enable_i = 0; acc_req_i = 1; tick();
        chk1("disable release", cs_n_o, 1'b1);
        acc_req_i = 0; tick(3); enable_i = 1; tick(4);
        req_pulse(); tick(); abort_i = 1; tick(); abort_i = 0; tick(4);

        tag = "R10";
        tmo_en_i = 1; tmo_val_i = 0; cs_min_high_i = 1;
        req_pulse();
        chk1("cs_n low", cs_n_o, 1'b0);
        tick();
        chk1("cs_n released first idle", cs_n_o, 1'b1);
        tick(4);

        tag = "mixed";
        for (int k = 0; k < 4000; k++) begin
            acc_req_i = ($urandom_range(0, 99) < 25);
            abort_i   = ($urandom_range(0, 99) < 2);
            if ($urandom_range(0, 199) == 0) enable_i = ~enable_i;
            if (!enable_i && $urandom_range(0, 9) == 0) begin
                tmo_en_i = $urandom_range(0, 3) != 0;
                tmo_val_i = $urandom_range(0, 6);
                cs_min_high_i = $urandom_range(0, 4);
            end
            if (!enable_i && $urandom_range(0, 19) == 0) enable_i = 1;
            tick();
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule